// File: doc/BRIEF.md
# Self-Starting Skip-Sequence Counter

This block is a 4-bit synchronous counter. Its counting order is fixed and has gaps. It starts at zero, climbs through the twelve legal codes, and returns to zero after fifteen. The codes four, five, eight and nine are never visited during normal counting. If the register does land on one of them, the next enabled clock moves it into the legal cycle, so the counter is self-starting.

A clock, an active-high count enable, an asynchronous active-low clear and a force path make up the interface. The force path is a 4-bit value plus a strobe. It lets a test environment or a neighbouring block place the register on any of the sixteen codes, unused ones included. The current code is visible on an output, and a separate combinational flag goes high while the register sits on an unused code.

The design is a named-state machine. The legal states are ZERO, ONE, TWO, THREE, SIX, SEVEN, TEN, ELEVEN, TWELVE, THIRTEEN, FOURTEEN and FIFTEEN, and the unused states are ORPH4, ORPH5, ORPH8 and ORPH9.

Legal-state transitions (these happen when enabled):
- ZERO→ONE→TWO→THREE→SIX→SEVEN→TEN→ELEVEN→TWELVE→THIRTEEN→FOURTEEN→FIFTEEN→ZERO

Recovery transitions:
- ORPH4→SIX and ORPH5→SIX
- ORPH8→TEN and ORPH9→TEN

Force and clear transitions:
- A force moves any state to the forced code.
- Clear moves any state to ZERO.

Top module: `skipseq_counter`

## Requirements
- R1: With the enable high (enable = 1) and no force, each rising edge moves a legal state to its successor in the order 0, 1, 2, 3, 6, 7, 10, 11, 12, 13, 14, 15.
- R2: With the enable high and no force, state 15 is followed by state 0.
- R3: With the enable high and no force, unused codes 4 and 5 each go to 6 in a single clock.
- R4: With the enable high and no force, unused codes 8 and 9 each go to 10 in a single clock.
- R5: The flag output is 1 exactly when the state output equals 4, 5, 8 or 9, and 0 for every other code.
- R6: Driving the clear low sets the state to 0 at once, without waiting for a clock edge, and holds it at 0 while the clear stays low.
- R7: When the force strobe is 1 at a rising edge, the state takes the 4-bit force value at that edge. The enable has no effect on this, so a force wins over counting and also works while counting is disabled.
- R8: When the enable is 0 and the strobe is 0, the state keeps its value across rising edges, and this applies to unused codes as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low, sets state 0 |
| cnt_en | input | 1 | Count enable, active high |
| frc_stb | input | 1 | Force strobe: loads frc_val at the next rising edge |
| frc_val | input | 4 | Code to force into the state register |
| state_q | output | 4 | Current state code |
| bad_code | output | 1 | High while state_q is 4, 5, 8 or 9 |

## Verification
On every clock, the assertions check the following:
- the single-step successor of each legal state, the wrap after fifteen, and the one-clock recovery from all four unused codes;
- that the state holds while the enable is low;
- the loading of the force value;
- the agreement between the flag and the state;
- the zero value while the clear is low.

Some behaviours only the bench scenarios can show:
- that the clear acts between clock edges;
- that all sixteen codes can be reached through the force path, with each one followed by its proper successor;
- that a long enabled run walks the whole cycle in order more than once.

// File: rtl/skipseq_pkg.sv
package skipseq_pkg;
    localparam int CW = 4;

    typedef enum logic [CW-1:0] {
        ZERO     = 4'd0,
        ONE      = 4'd1,
        TWO      = 4'd2,
        THREE    = 4'd3,
        ORPH4    = 4'd4,
        ORPH5    = 4'd5,
        SIX      = 4'd6,
        SEVEN    = 4'd7,
        ORPH8    = 4'd8,
        ORPH9    = 4'd9,
        TEN      = 4'd10,
        ELEVEN   = 4'd11,
        TWELVE   = 4'd12,
        THIRTEEN = 4'd13,
        FOURTEEN = 4'd14,
        FIFTEEN  = 4'd15
    } cnt_state_t;
endpackage

// File: rtl/skipseq_next.sv
module skipseq_next
    import skipseq_pkg::*;
(
    input  cnt_state_t        cur,
    input  logic              cnt_en,
    input  logic              frc_stb,
    input  logic [CW-1:0]     frc_val,
    output cnt_state_t        nxt
);
    cnt_state_t step;

    // Counting successor, including recovery arcs from unused codes.
    always_comb begin
        unique case (cur)
            ZERO:     step = ONE;
            ONE:      step = TWO;
            TWO:      step = THREE;
            THREE:    step = SIX;
            ORPH4:    step = SIX;
            ORPH5:    step = SIX;
            SIX:      step = SEVEN;
            SEVEN:    step = TEN;
            ORPH8:    step = TEN;
            ORPH9:    step = TEN;
            TEN:      step = ELEVEN;
            ELEVEN:   step = TWELVE;
            TWELVE:   step = THIRTEEN;
            THIRTEEN: step = FOURTEEN;
            FOURTEEN: step = FIFTEEN;
            FIFTEEN:  step = ZERO;
            default:  step = ZERO;
        endcase
    end

    // Force beats counting; disabled counting holds.
    always_comb begin
        if (frc_stb)
            nxt = cnt_state_t'(frc_val);
        else if (cnt_en)
            nxt = step;
        else
            nxt = cur;
    end
endmodule

// File: rtl/skipseq_reg.sv
module skipseq_reg
    import skipseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cnt_state_t nxt,
    output cnt_state_t cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur <= ZERO;
        else
            cur <= nxt;
    end
endmodule

// File: rtl/skipseq_flag.sv
module skipseq_flag
    import skipseq_pkg::*;
(
    input  cnt_state_t cur,
    output logic       bad
);
    always_comb begin
        unique case (cur)
            ORPH4, ORPH5, ORPH8, ORPH9: bad = 1'b1;
            default:                    bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/skipseq_counter.sv
module skipseq_counter
    import skipseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          frc_stb,
    input  logic [CW-1:0] frc_val,
    output logic [CW-1:0] state_q,
    output logic          bad_code
);
    cnt_state_t cur_s;
    cnt_state_t nxt_s;

    skipseq_next u_next (
        .cur     (cur_s),
        .cnt_en  (cnt_en),
        .frc_stb (frc_stb),
        .frc_val (frc_val),
        .nxt     (nxt_s)
    );

    skipseq_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_s),
        .cur   (cur_s)
    );

    skipseq_flag u_flag (
        .cur (cur_s),
        .bad (bad_code)
    );

    assign state_q = cur_s;
endmodule

// File: rtl/skipseq_chk.sv
module skipseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic       frc_stb,
    input logic [3:0] frc_val,
    input logic [3:0] state_q,
    input logic       bad_code
);
    function automatic logic [3:0] legal_succ(input logic [3:0] s);
        if (s == 4'd15) return 4'd0;
        if (s == 4'd3)  return 4'd6;
        if (s == 4'd7)  return 4'd10;
        return 4'(s + 4'd1);
    endfunction

    function automatic logic is_orphan(input logic [3:0] s);
        return (s == 4'd4) || (s == 4'd5) || (s == 4'd8) || (s == 4'd9);
    endfunction

    AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !frc_stb && !is_orphan(state_q) && state_q != 4'd15)
        |=> state_q == legal_succ($past(state_q))); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !frc_stb && state_q == 4'd15) |=> state_q == 4'd0); // R2

    AST_RECOVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !frc_stb && (state_q == 4'd4 || state_q == 4'd5))
        |=> state_q == 4'd6); // R3

    AST_RECOVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !frc_stb && (state_q == 4'd8 || state_q == 4'd9))
        |=> state_q == 4'd10); // R4

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code == is_orphan(state_q)); // R5

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_CLEAR_ZERO: assert (state_q == 4'd0); // R6
        end
    end

    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frc_stb |=> state_q == $past(frc_val)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !frc_stb) |=> $stable(state_q)); // R8
endmodule

bind skipseq_counter skipseq_chk u_chk (.*);

// File: tb/skipseq_counter_tb.sv
`timescale 1ns/1ps
module skipseq_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       frc_stb = 1'b0;
    logic [3:0] frc_val = 4'd0;
    logic [3:0] state_q;
    logic       bad_code;

    int n_chk = 0;
    int n_fail = 0;
    int model = 0;
    bit done = 0;
    int legal_seq[$] = '{0, 1, 2, 3, 6, 7, 10, 11, 12, 13, 14, 15};

    always #4 clk = ~clk;

    skipseq_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .frc_stb(frc_stb),
        .frc_val(frc_val), .state_q(state_q), .bad_code(bad_code)
    );

    // Reference: next legal code in list order; unused codes go to the next larger legal code.
    function automatic int ref_next(int s);
        foreach (legal_seq[i]) begin
            if (legal_seq[i] == s)
                return legal_seq[(i + 1) % legal_seq.size()];
        end
        foreach (legal_seq[i]) begin
            if (legal_seq[i] > s) return legal_seq[i];
        end
        return 0;
    endfunction

    function automatic bit ref_bad(int s);
        foreach (legal_seq[i]) if (legal_seq[i] == s) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (state_q !== 4'(model)) begin
            n_fail++;
            $display("FAIL %s state actual=%0d expected=%0d", tag, state_q, model);
        end
        n_chk++;
        if (bad_code !== ref_bad(model)) begin
            n_fail++;
            $display("FAIL R5 flag actual=%0b expected=%0b (state %0d)", bad_code, ref_bad(model), model);
        end
    endtask

    task automatic step(input bit en, input bit stb, input int val, input string tag);
        @(negedge clk);
        cnt_en = en;
        frc_stb = stb;
        frc_val = 4'(val);
        @(posedge clk);
        if (stb) model = val;
        else if (en) model = ref_next(model);
        #1;
        check(tag);
    endtask

    initial begin
        #3;
        model = 0;
        check("R6 reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 and R2: two full laps
        for (int k = 0; k < 26; k++) step(1, 0, 0, (model == 15) ? "R2" : "R1");

        // R8: hold on a legal code
        for (int k = 0; k < 4; k++) step(0, 0, 0, "R8");

        // R7, R3, R4, R1: force every code, then one enabled step
        for (int v = 0; v < 16; v++) begin
            step(0, 1, v, "R7");
            step(1, 0, 0, (v == 4 || v == 5) ? "R3" :
                          (v == 8 || v == 9) ? "R4" :
                          (v == 15) ? "R2" : "R1");
        end

        // R8: unused code holds while disabled
        step(0, 1, 9, "R7");
        for (int k = 0; k < 3; k++) step(0, 0, 0, "R8");
        step(1, 0, 0, "R4");

        // R7: force wins over counting
        step(1, 1, 5, "R7");
        step(1, 1, 12, "R7");
        step(1, 0, 0, "R1");

        // R6: asynchronous clear between edges
        @(negedge clk);
        cnt_en = 1'b0;
        #1;
        rst_n = 1'b0;
        #1;
        model = 0;
        check("R6 async");
        @(posedge clk);
        #1;
        check("R6 held");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 0, "R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule